// File: doc/BRIEF.md
# Capture-Compare Timer Status and Interrupt Logic

This block runs a 16-bit counter that advances by one on every clock and watches four kinds of timing events: a pulse on either of two capture inputs, a match between the counter and either of two 16-bit compare values, and the wrap of the counter from its top value back to zero. Each event raises a bit in a status byte. A bit falls only when software performs a two-step access. First it reads the status byte while the bit is up. Then it reads or writes the low byte of the register tied to that event. All registers sit behind a byte-wide register bus with single-cycle read and write strobes and combinational read data.

A five-bit flag register drives the interrupt path. Per-source enables in an interrupt-control byte gate it. Two group enables in a global-enable byte override the per-channel capture and compare enables. The result is one combined request, and a routing bit sends it to one of two outputs.

Each flag is a small state machine with three states. FL_IDLE means the flag is down. FL_PENDING means the flag is up but not armed for clearing. FL_ARMED means the flag is up and a status read has been seen. The transitions are:

| Transition | From | To | Cause |
|---|---|---|---|
| T_SET | FL_IDLE | FL_PENDING | the source event |
| T_ARM | FL_PENDING | FL_ARMED | a status read with no event in the same cycle |
| T_CLEAR | FL_ARMED | FL_IDLE | an access to the matching low byte |
| T_RESET_ARM | FL_ARMED | FL_PENDING | a new event, which takes priority over T_CLEAR |

Every other case holds the state. This includes a status read in FL_ARMED, which re-arms the flag.

Top module: `tmr_cc_top`

Register addresses (bus_addr):

| Address | Register |
|---|---|
| 0h / 1h | counter high / low (the low byte clears the overflow flag) |
| 2h / 3h | alias counter high / low (no clearing effect) |
| 4h / 5h | capture-1 high / low |
| 6h / 7h | capture-2 high / low |
| 8h / 9h | compare-1 high / low (read/write) |
| Ah / Bh | compare-2 high / low (read/write) |
| Ch | status (read-only) |
| Dh | interrupt control |
| Eh | global enables: bit 0 compare group, bit 1 capture group, bit 2 overflow enable |
| Fh | reads 00h |

## Requirements
- R1: The status byte resets to 00h. Its bits are: bit 7 capture-1, bit 6 compare-1, bit 5 overflow, bit 4 capture-2, bit 3 compare-2. Bits 2..0 always read 0.
- R2: Writes to the status address (Ch) change no flag.
- R3: A capture pulse on cap_in[i] loads that channel's capture register with the counter value present at that clock edge, and sets its status bit on the same edge.
- R4: A flag falls only after two steps. The first is a status read made while the flag is up. The second is a later read or write of that flag's own low byte: 5h capture-1, 9h compare-1, 1h overflow, 7h capture-2, Bh compare-2. Access to another channel's low byte, or access without the prior status read, leaves the flag up.
- R5: A flag that is set again after the status read and before (or at) the low-byte access stays up after that access.
- R6: A compare bit sets on the edge where the counter equals that channel's compare value. Compare values reset to FFFFh and are written bytewise at 8h/9h and Ah/Bh.
- R7: The interrupt-control byte (Dh) resets to 00h. Its bits are: bit 7 capture-1 enable, bit 6 compare-1 enable, bit 5 capture-2 enable, bit 4 compare-2 enable, bit 0 routing select. Bits 3..1 read 0.
- R8: The interrupt request is the OR of all flags whose enable is on. The overflow flag is enabled by bit 2 of Eh.
- R9: With routing select 0 the request drives irq_ext only. With routing select 1 it drives irq_tmr only.
- R10: Bit 1 of Eh enables both capture flags regardless of their per-channel bits. Bit 0 of Eh does the same for both compare flags.
- R11: The overflow bit sets when the counter wraps from FFFFh to 0000h. Accessing the alias low byte (3h) does not clear it.
- R12: The counter resets to 0 and increments by one every clock. It reads at 0h/1h and 2h/3h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cap_in | input | 2 | synchronized capture pulses, one per channel |
| bus_addr | input | 4 | register address |
| bus_rd | input | 1 | read strobe |
| bus_wr | input | 1 | write strobe |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for bus_addr |
| irq_ext | output | 1 | request routed to the external-interrupt path |
| irq_tmr | output | 1 | request routed to the timer interrupt output |

## Verification
The bound checker checks these properties on every clock:
- the always-zero bits of the status and control bytes;
- that a flag rises only on its own event and falls only right after an access to its own low byte;
- that an event always leaves its flag up on the next cycle;
- that the two interrupt outputs are never both high, and neither is high with no flag up;
- the one-per-clock counter step.

Only the bench's scenarios can show the ordered parts of the protocol: the status read must come first, an event between the read and the access must keep the flag up, and the alias counter byte must not clear overflow. The bench also covers the captured values, the group-enable overrides and the routing choice, checked against a behavioural model on every clock.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    localparam int CNT_W    = 16;
    localparam int NUM_CH   = 2;
    localparam int NUM_FLAG = 5;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;

    // flag index i maps to status bit (7 - i)
    localparam int FI_CAP1 = 0;
    localparam int FI_CMP1 = 1;
    localparam int FI_OVF  = 2;
    localparam int FI_CAP2 = 3;
    localparam int FI_CMP2 = 4;

    localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'h0;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'h1;
    localparam logic [ADDR_W-1:0] A_ALT_HI  = 4'h2;
    localparam logic [ADDR_W-1:0] A_ALT_LO  = 4'h3;
    localparam logic [ADDR_W-1:0] A_CAP_HI0 = 4'h4;
    localparam logic [ADDR_W-1:0] A_CMP_HI0 = 4'h8;
    localparam logic [ADDR_W-1:0] A_STATUS  = 4'hC;
    localparam logic [ADDR_W-1:0] A_IRQCTL  = 4'hD;
    localparam logic [ADDR_W-1:0] A_GLBEN   = 4'hE;

    typedef enum logic [1:0] {
        FL_IDLE    = 2'd0,
        FL_PENDING = 2'd1,
        FL_ARMED   = 2'd2
    } flag_state_e;

    function automatic logic [ADDR_W-1:0] cap_hi_addr(input int ch);
        return A_CAP_HI0 + ADDR_W'(2 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_hi_addr(input int ch);
        return A_CMP_HI0 + ADDR_W'(2 * ch);
    endfunction

    // low-byte address whose access completes the clear of a flag
    function automatic logic [ADDR_W-1:0] clear_addr(input int fi);
        case (fi)
            FI_CAP1: return cap_hi_addr(0) + 1'b1;
            FI_CMP1: return cmp_hi_addr(0) + 1'b1;
            FI_OVF:  return A_CNT_LO;
            FI_CAP2: return cap_hi_addr(1) + 1'b1;
            default: return cmp_hi_addr(1) + 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tmr_cc_counter.sv
module tmr_cc_counter
    import tmr_cc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt,
    output logic         wrap_ev
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // the next edge takes the counter from all-ones to zero
    assign wrap_ev = &cnt;

endmodule

// File: rtl/tmr_cc_capture.sv
module tmr_cc_capture
    import tmr_cc_pkg::*;
#(
    parameter int W   = CNT_W,
    parameter int NCH = NUM_CH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          cap_in,
    input  logic [W-1:0]            cnt,
    output logic [NCH-1:0][W-1:0]   cap_val,
    output logic [NCH-1:0]          cap_ev
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_val[ch] <= '0;
            end else if (cap_in[ch]) begin
                cap_val[ch] <= cnt;
            end
        end
    end

    assign cap_ev = cap_in;

endmodule

// File: rtl/tmr_cc_compare.sv
module tmr_cc_compare
    import tmr_cc_pkg::*;
#(
    parameter int W   = CNT_W,
    parameter int NCH = NUM_CH,
    parameter int DW  = DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          wr_hi,
    input  logic [NCH-1:0]          wr_lo,
    input  logic [DW-1:0]           wdata,
    input  logic [W-1:0]            cnt,
    output logic [NCH-1:0][W-1:0]   cmp_val,
    output logic [NCH-1:0]          match_ev
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_val[ch] <= '1;
            end else begin
                if (wr_hi[ch]) cmp_val[ch][W-1:DW] <= wdata;
                if (wr_lo[ch]) cmp_val[ch][DW-1:0] <= wdata;
            end
        end
        assign match_ev[ch] = (cnt == cmp_val[ch]);
    end

endmodule

// File: rtl/tmr_cc_flag.sv
module tmr_cc_flag
    import tmr_cc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic st_rd,
    input  logic clr_acc,
    output logic flag
);

    flag_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: begin
                if (set_ev) state_d = FL_PENDING;          // T_SET
            end
            FL_PENDING: begin
                if (!set_ev && st_rd) state_d = FL_ARMED;  // T_ARM
            end
            FL_ARMED: begin
                if (set_ev)       state_d = FL_PENDING;    // T_RESET_ARM
                else if (clr_acc) state_d = FL_IDLE;       // T_CLEAR
            end
            default: state_d = FL_IDLE;
        endcase
    end

    // output
    always_comb begin
        flag = (state_q != FL_IDLE);
    end

endmodule

// File: rtl/tmr_cc_top.sv
module tmr_cc_top
    import tmr_cc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cap_in,
    input  logic [3:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq_ext,
    output logic        irq_tmr
);

    localparam int HB = CNT_W - 1;
    localparam int LB = DATA_W - 1;

    logic [CNT_W-1:0]              cnt_q;
    logic                          wrap_ev;
    logic [NUM_CH-1:0][CNT_W-1:0]  cap_val;
    logic [NUM_CH-1:0]             cap_ev;
    logic [NUM_CH-1:0][CNT_W-1:0]  cmp_val;
    logic [NUM_CH-1:0]             match_ev;
    logic [NUM_CH-1:0]             cmp_wr_hi, cmp_wr_lo;
    logic [NUM_FLAG-1:0]           flag_ev, flag_q, flag_en, clr_acc;
    logic [DATA_W-1:0]             status_b;
    logic [DATA_W-1:0]             irqctl_q;
    logic [2:0]                    glben_q;
    logic                          st_rd, bus_acc, irq_any;

    assign bus_acc = bus_rd | bus_wr;
    assign st_rd   = bus_rd && (bus_addr == A_STATUS);

    tmr_cc_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt_q),
        .wrap_ev (wrap_ev)
    );

    tmr_cc_capture #(.W(CNT_W), .NCH(NUM_CH)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_in  (cap_in),
        .cnt     (cnt_q),
        .cap_val (cap_val),
        .cap_ev  (cap_ev)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmpdec
        assign cmp_wr_hi[ch] = bus_wr && (bus_addr == cmp_hi_addr(ch));
        assign cmp_wr_lo[ch] = bus_wr && (bus_addr == cmp_hi_addr(ch) + 1'b1);
    end

    tmr_cc_compare #(.W(CNT_W), .NCH(NUM_CH), .DW(DATA_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hi    (cmp_wr_hi),
        .wr_lo    (cmp_wr_lo),
        .wdata    (bus_wdata),
        .cnt      (cnt_q),
        .cmp_val  (cmp_val),
        .match_ev (match_ev)
    );

    // event routing into flag slots
    assign flag_ev[FI_CAP1] = cap_ev[0];
    assign flag_ev[FI_CMP1] = match_ev[0];
    assign flag_ev[FI_OVF]  = wrap_ev;
    assign flag_ev[FI_CAP2] = cap_ev[1];
    assign flag_ev[FI_CMP2] = match_ev[1];

    for (genvar fi = 0; fi < NUM_FLAG; fi++) begin : g_flag
        assign clr_acc[fi] = bus_acc && (bus_addr == clear_addr(fi));
        tmr_cc_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_ev  (flag_ev[fi]),
            .st_rd   (st_rd),
            .clr_acc (clr_acc[fi]),
            .flag    (flag_q[fi])
        );
        assign status_b[DATA_W-1-fi] = flag_q[fi];
    end
    assign status_b[DATA_W-NUM_FLAG-1:0] = '0;

    // control bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irqctl_q <= '0;
            glben_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_IRQCTL) irqctl_q <= {bus_wdata[7:4], 3'b000, bus_wdata[0]};
            if (bus_addr == A_GLBEN)  glben_q  <= bus_wdata[2:0];
        end
    end

    // group enables override per-channel ones
    assign flag_en[FI_CAP1] = glben_q[1] | irqctl_q[7];
    assign flag_en[FI_CMP1] = glben_q[0] | irqctl_q[6];
    assign flag_en[FI_CAP2] = glben_q[1] | irqctl_q[5];
    assign flag_en[FI_CMP2] = glben_q[0] | irqctl_q[4];
    assign flag_en[FI_OVF]  = glben_q[2];

    assign irq_any = |(flag_q & flag_en);
    assign irq_ext = irq_any & ~irqctl_q[0];
    assign irq_tmr = irq_any &  irqctl_q[0];

    // read data
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            4'h0, 4'h2: bus_rdata = cnt_q[HB:DATA_W];
            4'h1, 4'h3: bus_rdata = cnt_q[LB:0];
            4'h4:       bus_rdata = cap_val[0][HB:DATA_W];
            4'h5:       bus_rdata = cap_val[0][LB:0];
            4'h6:       bus_rdata = cap_val[1][HB:DATA_W];
            4'h7:       bus_rdata = cap_val[1][LB:0];
            4'h8:       bus_rdata = cmp_val[0][HB:DATA_W];
            4'h9:       bus_rdata = cmp_val[0][LB:0];
            4'hA:       bus_rdata = cmp_val[1][HB:DATA_W];
            4'hB:       bus_rdata = cmp_val[1][LB:0];
            4'hC:       bus_rdata = status_b;
            4'hD:       bus_rdata = irqctl_q;
            4'hE:       bus_rdata = {5'b00000, glben_q};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk
    import tmr_cc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           bus_addr,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [7:0]           bus_rdata,
    input logic                 irq_ext,
    input logic                 irq_tmr,
    input logic [NUM_FLAG-1:0]  flags,
    input logic [NUM_FLAG-1:0]  events,
    input logic [CNT_W-1:0]     cnt
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_status_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STATUS) |-> (bus_rdata[2:0] == 3'b000));

    p_ctrl_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_IRQCTL) |-> (bus_rdata[3:1] == 3'b000));

    p_route_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ext && irq_tmr));

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ext || irq_tmr) |-> (flags != '0));

    p_count_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

    for (genvar fi = 0; fi < NUM_FLAG; fi++) begin : g_fl
        // R3 / R6 / R11: a flag rises only on its own event; R2 follows
        p_rise_on_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $rose(flags[fi])) |-> $past(events[fi]));

        p_fall_on_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $fell(flags[fi])) |->
                $past((bus_rd || bus_wr) && (bus_addr == clear_addr(fi))));

        p_event_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
            events[fi] |=> flags[fi]);
    end

endmodule

bind tmr_cc_top tmr_cc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq_ext   (irq_ext),
    .irq_tmr   (irq_tmr),
    .flags     (flag_q),
    .events    (flag_ev),
    .cnt       (cnt_q)
);

// File: tb/sim_tmr_cc_top.sv
`timescale 1ns/1ps
module sim_tmr_cc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cap_in = 2'b00;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_ext, irq_tmr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    tmr_cc_top u0 (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ext(irq_ext), .irq_tmr(irq_tmr)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt;
    int m_cap [2];
    int m_cmp [2];
    int m_st  [5];   // 0 down, 1 up, 2 up and armed
    int m_c3, m_c1;
    int clr_a [5] = '{5, 9, 1, 7, 11};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            foreach (m_cap[k]) m_cap[k] = 0;
            foreach (m_cmp[k]) m_cmp[k] = 65535;
            foreach (m_st[k])  m_st[k] = 0;
            m_c3 = 0; m_c1 = 0;
        end else begin
            bit ev [5];
            bit strd;
            ev[0] = cap_in[0];
            ev[1] = (m_cnt == m_cmp[0]);
            ev[2] = (m_cnt == 65535);
            ev[3] = cap_in[1];
            ev[4] = (m_cnt == m_cmp[1]);
            strd = bus_rd && (bus_addr == 4'hC);
            for (int k = 0; k < 5; k++) begin
                bit acc;
                acc = (bus_rd || bus_wr) && (int'(bus_addr) == clr_a[k]);
                if (ev[k]) m_st[k] = 1;
                else if (m_st[k] == 1 && strd) m_st[k] = 2;
                else if (m_st[k] == 2 && acc) m_st[k] = 0;
            end
            for (int k = 0; k < 2; k++) if (cap_in[k]) m_cap[k] = m_cnt;
            if (bus_wr) begin
                case (bus_addr)
                    4'h8: m_cmp[0] = (m_cmp[0] & 255) | (int'(bus_wdata) << 8);
                    4'h9: m_cmp[0] = (m_cmp[0] & 65280) | int'(bus_wdata);
                    4'hA: m_cmp[1] = (m_cmp[1] & 255) | (int'(bus_wdata) << 8);
                    4'hB: m_cmp[1] = (m_cmp[1] & 65280) | int'(bus_wdata);
                    4'hD: m_c3 = int'(bus_wdata) & 8'hF1;
                    4'hE: m_c1 = int'(bus_wdata) & 7;
                    default: ;
                endcase
            end
            m_cnt = (m_cnt + 1) % 65536;
        end
    end

    function automatic int m_status();
        int s = 0;
        for (int k = 0; k < 5; k++) if (m_st[k] != 0) s |= (1 << (7 - k));
        return s;
    endfunction

    function automatic logic [7:0] m_rdata(input logic [3:0] a);
        case (a)
            4'h0, 4'h2: return 8'(m_cnt >> 8);
            4'h1, 4'h3: return 8'(m_cnt);
            4'h4: return 8'(m_cap[0] >> 8);
            4'h5: return 8'(m_cap[0]);
            4'h6: return 8'(m_cap[1] >> 8);
            4'h7: return 8'(m_cap[1]);
            4'h8: return 8'(m_cmp[0] >> 8);
            4'h9: return 8'(m_cmp[0]);
            4'hA: return 8'(m_cmp[1] >> 8);
            4'hB: return 8'(m_cmp[1]);
            4'hC: return 8'(m_status());
            4'hD: return 8'(m_c3);
            4'hE: return 8'(m_c1);
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic m_irq();
        bit en [5];
        bit r = 0;
        en[0] = ((m_c1 >> 1) & 1) != 0 || ((m_c3 >> 7) & 1) != 0;
        en[1] = ((m_c1 >> 0) & 1) != 0 || ((m_c3 >> 6) & 1) != 0;
        en[2] = ((m_c1 >> 2) & 1) != 0;
        en[3] = ((m_c1 >> 1) & 1) != 0 || ((m_c3 >> 5) & 1) != 0;
        en[4] = ((m_c1 >> 0) & 1) != 0 || ((m_c3 >> 4) & 1) != 0;
        for (int k = 0; k < 5; k++) if (m_st[k] != 0 && en[k]) r = 1;
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        if (a <= 4'h3) return "R12";
        if (a <= 4'h7) return "R3";
        if (a <= 4'hB) return "R6";
        if (a == 4'hD) return "R7";
        if (a == 4'hE) return "R10";
        return "R1";
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [7:0] er;
            logic ee, et;
            er = m_rdata(bus_addr);
            ee = m_irq() && ((m_c3 & 1) == 0);
            et = m_irq() && ((m_c3 & 1) != 0);
            checks++;
            if (bus_rdata !== er) begin
                failures++;
                $display("FAIL %s model rdata addr=%h actual=%h expected=%h",
                         tag_of(bus_addr), bus_addr, bus_rdata, er);
            end
            checks++;
            if (irq_ext !== ee || irq_tmr !== et) begin
                failures++;
                $display("FAIL R9 model irq actual=%b%b expected=%b%b",
                         irq_ext, irq_tmr, ee, et);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #3 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input int ch);
        @(negedge clk);
        cap_in[ch] = 1'b1;
        @(negedge clk);
        cap_in[ch] = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] a,
                              input logic [7:0] mask, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(tag, int'(d & mask), int'(exp & mask));
    endtask

    task automatic expect_irq(input string tag, input logic e, input logic t);
        #3;
        check(tag, {30'd0, irq_ext, irq_tmr}, {30'd0, e, t});
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] d;
        int cap_exp, tgt;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // reset values
        expect_reg("R1 reset status", 4'hC, 8'hFF, 8'h00);
        expect_reg("R7 reset irqctl", 4'hD, 8'hFF, 8'h00);
        expect_reg("R6 reset cmp1 hi", 4'h8, 8'hFF, 8'hFF);

        // R7 reserved bits
        wr(4'hD, 8'hFF);
        expect_reg("R7 reserved zero", 4'hD, 8'hFF, 8'hF1);
        wr(4'hD, 8'h00);

        // R2 status ignores writes
        wr(4'hC, 8'hFF);
        expect_reg("R2 status write ignored", 4'hC, 8'hFF, 8'h00);

        // R12 counter step
        rd(4'h1, d);
        tgt = int'(d);
        rd(4'h3, d);
        check("R12 counter step", int'(d), (tgt + 2) % 256);

        // R3 capture 1
        @(negedge clk);
        cap_exp = m_cnt;
        cap_in[0] = 1'b1;
        @(negedge clk);
        cap_in[0] = 1'b0;
        rd(4'h5, d);   // low-byte access without status read: no clear
        check("R3 capture low", int'(d), cap_exp % 256);
        expect_reg("R3 capture high", 4'h4, 8'hFF, 8'(cap_exp >> 8));
        expect_reg("R4 no clear without status read", 4'hC, 8'hFF, 8'h80);
        rd(4'h7, d);   // wrong channel
        expect_reg("R4 other channel leaves flag", 4'hC, 8'hFF, 8'h80);
        rd(4'h5, d);
        expect_reg("R4 two-step clear", 4'hC, 8'hFF, 8'h00);

        // R5 re-set between read and access
        pulse(1);
        expect_reg("R3 capture2 flag", 4'hC, 8'hFF, 8'h10);
        pulse(1);
        wr(4'h7, 8'h00);
        expect_reg("R5 re-set flag stays", 4'hC, 8'hFF, 8'h10);
        rd(4'h7, d);
        expect_reg("R4 clear after re-arm", 4'hC, 8'hFF, 8'h00);

        // R6 compare 1 and 2
        tgt = (m_cnt + 40) % 65536;
        wr(4'h8, 8'(tgt >> 8));
        wr(4'h9, 8'(tgt));
        expect_reg("R6 no early match", 4'hC, 8'hFF, 8'h00);
        repeat (45) @(negedge clk);
        expect_reg("R6 compare1 flag", 4'hC, 8'hFF, 8'h40);
        wr(4'h9, 8'(tgt));
        tgt = (m_cnt + 40) % 65536;
        wr(4'hA, 8'(tgt >> 8));
        wr(4'hB, 8'(tgt));
        repeat (45) @(negedge clk);
        expect_reg("R6 compare2 flag", 4'hC, 8'hFF, 8'h08);
        wr(4'hB, 8'(tgt));
        expect_reg("R4 compare clears", 4'hC, 8'hFF, 8'h00);

        // R8 / R9 / R10 interrupt combine and routing
        wr(4'hD, 8'h80);
        pulse(1);
        expect_irq("R8 disabled source", 1'b0, 1'b0);
        pulse(0);
        expect_irq("R8 enabled source ext", 1'b1, 1'b0);
        wr(4'hD, 8'h81);
        expect_irq("R9 routed to timer", 1'b0, 1'b1);
        rd(4'hC, d);
        rd(4'h5, d);
        rd(4'h7, d);
        expect_irq("R8 cleared no request", 1'b0, 1'b0);
        wr(4'hD, 8'h00);
        wr(4'hE, 8'h02);
        pulse(1);
        expect_irq("R10 group capture enable", 1'b1, 1'b0);
        rd(4'hC, d);
        rd(4'h7, d);
        wr(4'hE, 8'h00);

        // R11 overflow
        wait (m_cnt == 65530);
        repeat (20) @(negedge clk);
        expect_reg("R11 overflow flag", 4'hC, 8'h20, 8'h20);
        rd(4'h3, d);
        expect_reg("R11 alias keeps flag", 4'hC, 8'h20, 8'h20);
        rd(4'h1, d);
        expect_reg("R11 main low clears", 4'hC, 8'h20, 8'h00);

        repeat (4) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule